// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the stream of column addresses that a memory controller issues for that burst. A one-cycle start pulse carries the starting column, a burst length code and an ordering choice. From the next clock onward the block offers one column address per beat on a valid/ready output stream. A fixed-length burst stops by itself after its last beat. A full-page burst keeps counting upward until it is terminated or restarted.

A new start may arrive on any cycle, including in the middle of a burst. The addresses of the old burst that have not yet been handed over are dropped, and the new burst runs its full programmed length. If a write start cuts into a read burst, a data-mask output is raised for a fixed number of cycles so that the controller can keep the data bus free while it turns around.

The output obeys normal stream rules. A beat transfers on a clock edge where `col_valid` and `col_ready` are both high. While `col_valid` is high and `col_ready` is low, the address and the last flag hold steady. Only a start or a terminate can withdraw a beat that has not transferred. `col_valid` never waits on `col_ready`.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `col_valid`, `col_last` and `data_mask` are low.
- R2: The cycle after a start pulse, `col_valid` is high and `col_addr` equals the starting column.
- R3: In sequential order (`interleave`=0), the low log2(BL) bits count up by one per transferred beat from their starting value and wrap modulo BL. Column bits above that field stay equal to the starting column.
- R4: In interleaved order (`interleave`=1), the low log2(BL) bits of beat k equal the starting low bits XOR k. The upper bits are held as in R3.
- R5: `bl_code` selects the burst length: 0 = 2 beats, 1 = 4 beats, 2 = 8 beats, 3 = full page. A fixed-length burst transfers exactly BL beats. `col_last` is high only on the final beat, and `col_valid` is low in the cycle after that beat transfers.
- R6: A full-page burst uses sequential order whatever `interleave` is. It increments the whole column and wraps from the last column of the page (2^COL_W columns) to column 0. It never raises `col_last`.
- R7: `term` high while a full-page burst is active ends that burst: `col_valid` is low the next cycle. `term` has no effect on a fixed-length burst.
- R8: A start on any cycle discards the rest of the current burst and begins the new burst at its first beat with its full length.
- R9: Burst length and order are captured at the start pulse. Changing `bl_code` or `interleave` during a burst has no effect on that burst.
- R10: While `col_valid` is high and `col_ready` is low, with no start and no terminate, `col_addr` and `col_valid` keep their values on the next cycle.
- R11: A start with `is_write`=1 that arrives while a read burst is active raises `data_mask` for exactly MASK_CYC cycles, starting the next cycle. Otherwise `data_mask` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle burst start pulse |
| start_col | input | COL_W | Starting column address |
| bl_code | input | 2 | Burst length code (see R5) |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| is_write | input | 1 | The starting burst is a write |
| term | input | 1 | Terminates a full-page burst |
| col_valid | output | 1 | Column address beat valid |
| col_ready | input | 1 | Consumer accepts the beat |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| data_mask | output | 1 | Bus-contention mask after a read-to-write interrupt |

## Verification
The bench runs bursts that start near the top of the length field and near the top of the page. A design that carries out of the field into the upper bits, or that fails to wrap the page, gives a wrong address there. Interleaved and sequential runs use start values whose two orders differ, so swapping XOR and add cannot go unnoticed. Mid-burst restarts check that the old beats vanish and the new burst runs its full count. They also check that `data_mask` rises only for a write that cuts into a read, and falls after its exact cycle count. Stall, terminate-on-fixed and mid-burst configuration changes expose designs that advance without a handshake, stop a fixed burst early or re-read the length code.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    BL_TWO   = 2'd0,
    BL_FOUR  = 2'd1,
    BL_EIGHT = 2'd2,
    BL_PAGE  = 2'd3
  } bl_code_e;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec #(
  parameter int COL_W = 8
) (
  input  logic [1:0]       code,
  output logic [COL_W-1:0] span_mask,
  output logic             full_page
);
  import bcs_pkg::*;

  always_comb begin
    full_page = 1'b0;
    unique case (bl_code_e'(code))
      BL_TWO:   span_mask = COL_W'(1);
      BL_FOUR:  span_mask = COL_W'(3);
      BL_EIGHT: span_mask = COL_W'(7);
      default: begin
        span_mask = '1;
        full_page = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] span_mask,
  input  logic             xor_order,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] low;

  always_comb begin
    low  = xor_order ? (base ^ beat) : (base + beat);
    addr = (base & ~span_mask) | (low & span_mask);
  end
endmodule

// File: rtl/bcs_mask_timer.sv
module bcs_mask_timer #(
  parameter int MASK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic mask
);
  localparam int CNT_W = $clog2(MASK_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (trig)          cnt <= CNT_W'(MASK_CYC);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign mask = (cnt != '0);

  assert_mask_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask) |-> $past(trig));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W    = 8,
  parameter int MASK_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             term,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             data_mask
);
  logic             act_q, wr_q, full_q, xor_q;
  logic [COL_W-1:0] base_q, span_q, beat_q;
  logic [COL_W-1:0] span_d;
  logic             full_d;
  logic             fire, at_end, stop_pg, mask_trig;

  bcs_len_dec #(.COL_W(COL_W)) u_dec (
    .code(bl_code), .span_mask(span_d), .full_page(full_d)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base(base_q), .beat(beat_q), .span_mask(span_q),
    .xor_order(xor_q), .addr(col_addr)
  );

  assign mask_trig = start && is_write && act_q && !wr_q;

  bcs_mask_timer #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk(clk), .rst_n(rst_n), .trig(mask_trig), .mask(data_mask)
  );

  assign fire    = act_q && col_ready;
  assign at_end  = !full_q && (beat_q == span_q);
  assign stop_pg = act_q && full_q && term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      full_q <= 1'b0;
      xor_q  <= 1'b0;
      base_q <= '0;
      span_q <= '0;
      beat_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      wr_q   <= is_write;
      full_q <= full_d;
      xor_q  <= interleave && !full_d;
      base_q <= start_col;
      span_q <= span_d;
      beat_q <= '0;
    end else if (stop_pg) begin
      act_q <= 1'b0;
    end else if (fire) begin
      if (at_end) act_q  <= 1'b0;
      else        beat_q <= beat_q + 1'b1;
    end
  end

  assign col_valid = act_q;
  assign col_last  = act_q && at_end;

  assert_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start && !term) |=>
      (col_valid && $stable(col_addr)));

  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last && !start) |=> !col_valid);

  assert_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && term && full_q && !start) |=> !col_valid);

  assert_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !full_q) |-> (((col_addr ^ base_q) & ~span_q) == '0));

  assert_nolast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_q) |-> !col_last);
endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  localparam int COL_W    = 8;
  localparam int MASK_CYC = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       bl_code = '0;
  logic             interleave = 1'b0;
  logic             is_write = 1'b0;
  logic             term = 1'b0;
  logic             col_ready = 1'b1;
  logic             col_valid, col_last, data_mask;
  logic [COL_W-1:0] col_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .MASK_CYC(MASK_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .is_write(is_write),
    .term(term), .col_valid(col_valid), .col_ready(col_ready),
    .col_addr(col_addr), .col_last(col_last), .data_mask(data_mask)
  );

  typedef struct packed {
    logic [7:0]  col;
    logic [1:0]  bl;
    logic        il;
    logic [3:0]  n;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h12, 2'd0, 1'b0, 4'd2, 64'h1213_0000_0000_0000},
    '{8'h13, 2'd0, 1'b0, 4'd2, 64'h1312_0000_0000_0000},
    '{8'h2A, 2'd1, 1'b0, 4'd4, 64'h2A2B_2829_0000_0000},
    '{8'h29, 2'd1, 1'b1, 4'd4, 64'h2928_2B2A_0000_0000},
    '{8'h45, 2'd2, 1'b1, 4'd8, 64'h4544_4746_4140_4342},
    '{8'h45, 2'd2, 1'b0, 4'd8, 64'h4546_4740_4142_4344},
    '{8'hF3, 2'd2, 1'b1, 4'd8, 64'hF3F2_F1F0_F7F6_F5F4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic go(input logic [7:0] c, input logic [1:0] b, input logic il, input logic wr);
    start = 1'b1; start_col = c; bl_code = b; interleave = il; is_write = wr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", col_last, 0);
    chk("R1 mask", data_mask, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", col_valid, 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      go(VECS[v].col, VECS[v].bl, VECS[v].il, 1'b0);
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        chk("R2 valid", col_valid, 1);
        chk(VECS[v].il ? "R4 addr" : "R3 addr", col_addr, VECS[v].exp[63-8*k -: 8]);
        chk("R5 last", col_last, (k == int'(VECS[v].n) - 1));
        @(negedge clk);
      end
      chk("R5 end", col_valid, 0);
    end

    // R6 full page, interleave ignored, wrap at page end
    go(8'hFE, 2'd3, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      chk("R6 addr", col_addr, 8'(8'hFE + k));
      chk("R6 last", col_last, 0);
      if (k == 4) term = 1'b1;
      @(negedge clk);
    end
    term = 1'b0;
    chk("R7 term page", col_valid, 0);

    // R7 term ignored in fixed burst
    go(8'h10, 2'd2, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      chk("R7 fixed addr", col_addr, 8'h10 + k);
      term = (k == 1);
      @(negedge clk);
    end
    term = 1'b0;
    chk("R7 fixed end", col_valid, 0);

    // R10 back-pressure
    col_ready = 1'b0;
    go(8'h2A, 2'd1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk("R10 hold", col_addr, 8'h2A);
      chk("R10 valid", col_valid, 1);
      @(negedge clk);
    end
    col_ready = 1'b1;
    chk("R10 addr0", col_addr, 8'h2A);
    @(negedge clk);
    chk("R10 addr1", col_addr, 8'h2B);
    @(negedge clk);
    chk("R10 addr2", col_addr, 8'h28);
    @(negedge clk);
    chk("R10 addr3", col_addr, 8'h29);
    @(negedge clk);
    chk("R10 end", col_valid, 0);

    // R8 R11 write interrupts read
    go(8'h45, 2'd2, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 mid", col_addr, 8'h40);
    go(8'h81, 2'd1, 1'b0, 1'b1);
    chk("R8 new0", col_addr, 8'h81);
    chk("R11 mask1", data_mask, 1);
    @(negedge clk);
    chk("R8 new1", col_addr, 8'h82);
    chk("R11 mask2", data_mask, 1);
    @(negedge clk);
    chk("R8 new2", col_addr, 8'h83);
    chk("R11 mask off", data_mask, 0);
    @(negedge clk);
    chk("R8 new3", col_addr, 8'h80);
    chk("R8 last", col_last, 1);
    @(negedge clk);
    chk("R8 end", col_valid, 0);

    // R11 write over write: no mask; R8 full length
    go(8'h50, 2'd1, 1'b0, 1'b1);
    @(negedge clk);
    go(8'h60, 2'd1, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R8 ww addr", col_addr, 8'h60 + k);
      chk("R11 no mask", data_mask, 0);
      @(negedge clk);
    end
    chk("R8 ww end", col_valid, 0);

    // R9 config change mid-burst
    go(8'h29, 2'd1, 1'b0, 1'b0);
    bl_code = 2'd2; interleave = 1'b1;
    chk("R9 a0", col_addr, 8'h29);
    @(negedge clk);
    chk("R9 a1", col_addr, 8'h2A);
    @(negedge clk);
    chk("R9 a2", col_addr, 8'h2B);
    @(negedge clk);
    chk("R9 a3", col_addr, 8'h28);
    chk("R9 last", col_last, 1);
    @(negedge clk);
    chk("R9 end", col_valid, 0);

    finish_run();
  end
endmodule